// File: doc/BRIEF.md
# Display Register SPI Write Sequencer

This block brings up and powers down a small TFT panel controller over a write-only SPI link. The host issues one of four commands (power-up, shutdown, resume, suspend) with a 16-bit mode word that selects orientation, flip, colour order and inversion. The block turns that command into an ordered list of indexed register writes. Each write is sent as two 24-bit chip-select frames: an index frame that names the register, then a data frame that carries the value.

The host sees only a busy level and a one-cycle done pulse. A command that arrives while a sequence is running is dropped. The serial clock is derived from the system clock by a parameter, so the same block can serve panels with different SPI speed limits.

Top module: `panel_cfg_spi`

## Requirements
- R1: After reset csN is high, sclk is low, and busy and done are low.
- R2: Each frame is 24 bits sent MSB first in SPI mode 0. MOSI changes only while sclk is low and is sampled on the rising edge of sclk. One sclk period lasts 2*HALF_DIV system clocks.
- R3: A register write is an index frame of bytes 0x74, 0x00, register number, followed by a data frame of bytes 0x76, value[15:8], value[7:0].
- R4: Command code 0 (power-up) writes register 0x11 with 0x0000, then writes register 0x01 with the output-control value.
- R5: Command code 2 (resume) writes register 0x01 with the output-control value, then writes register 0x11 with 0x0000.
- R6: Command codes 1 (shutdown) and 3 (suspend) each send a single write of 0x0001 to register 0x11.
- R7: The output-control value is (0x2AEF & ~MODE_MASK) | (mode & MODE_MASK), with MODE_MASK = 0x6A00 by default. Mode bits outside the mask have no effect.
- R8: The mode word is captured when a command is accepted. Later changes on the mode input do not affect the running sequence.
- R9: csN stays high for at least 2*HALF_DIV system clocks between frames.
- R10: busy is high from the cycle after acceptance until the last frame ends. done is then high for exactly one cycle, in the first cycle that busy is low.
- R11: A cmdValid pulse while busy is high is ignored: no extra frames are sent and the running sequence is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code: 0 power-up, 1 shutdown, 2 resume, 3 suspend |
| cmdValid | input | 1 | Command strobe, accepted only when idle |
| mode | input | 16 | Orientation and colour-order mode word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| sclk | output | 1 | SPI serial clock (mode 0) |
| mosi | output | 1 | SPI serial data out |
| csN | output | 1 | SPI chip select, active low |

## Verification
A scoreboard rebuilds every frame from the sclk and mosi pins and compares it with frames the bench predicts from the command and mode. Power-up and resume are both run, so a register order swapped between them is caught. Shutdown and suspend are run to show that they send the same single write. All-zero, all-one and partial mode words show whether the mask is applied correctly. Two tests change the mode input, or send a second command, while a sequence is busy; these separate capture at acceptance from sampling that happens later.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;
  localparam int FRAME_BITS = 24;

  typedef enum logic [1:0] {
    CMD_POWER_UP = 2'd0,
    CMD_SHUTDOWN = 2'd1,
    CMD_RESUME   = 2'd2,
    CMD_SUSPEND  = 2'd3
  } cfg_cmd_e;

  // strobe bundle from sequencer to frame shifter
  typedef struct packed {
    logic                  launch;
    logic [FRAME_BITS-1:0] frame;
  } frame_req_t;

  localparam logic [7:0]  IDX_PREFIX = 8'h74;
  localparam logic [7:0]  DAT_PREFIX = 8'h76;
  localparam logic [7:0]  REG_SHUT   = 8'h11;
  localparam logic [7:0]  REG_DRV    = 8'h01;
  localparam logic [15:0] VAL_OFF    = 16'h0001;
  localparam logic [15:0] VAL_ON     = 16'h0000;
endpackage

// File: rtl/panel_cfg_shifter.sv
module panel_cfg_shifter
  import panel_cfg_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  frame_req_t req,
  output logic       frameDone,
  output logic       sclk,
  output logic       mosi,
  output logic       csN
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int BIT_W = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_state_e;

  sh_state_e             state;
  logic [FRAME_BITS-1:0] shReg;
  logic [DIV_W-1:0]      divCnt;
  logic [GAP_W-1:0]      gapCnt;
  logic [BIT_W-1:0]      bitCnt;
  logic                  tick;

  assign tick = (divCnt == DIV_W'(HALF_DIV - 1));
  assign mosi = (state == SH_SHIFT) ? shReg[FRAME_BITS-1] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SH_IDLE;
      shReg     <= '0;
      divCnt    <= '0;
      gapCnt    <= '0;
      bitCnt    <= '0;
      sclk      <= 1'b0;
      csN       <= 1'b1;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (state)
        SH_IDLE: begin
          if (req.launch) begin
            shReg  <= req.frame;
            csN    <= 1'b0;
            sclk   <= 1'b0;
            divCnt <= '0;
            bitCnt <= '0;
            state  <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            sclk   <= ~sclk;
            if (sclk) begin
              // falling edge: next bit or end of frame
              if (bitCnt == BIT_W'(FRAME_BITS - 1)) begin
                csN    <= 1'b1;
                gapCnt <= '0;
                state  <= SH_GAP;
              end else begin
                shReg  <= {shReg[FRAME_BITS-2:0], 1'b0};
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        SH_GAP: begin
          if (gapCnt == GAP_W'(GAP_CYC - 1)) begin
            frameDone <= 1'b1;
            state     <= SH_IDLE;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  // R2: serial clock parks low outside a frame
  a_r2_sclk_parked: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  // R2: data is settled before each rising sclk edge
  a_r2_mosi_settled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(mosi));
  // R9: frame completion follows a raised chip select
  a_r9_done_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> csN && $past(csN));
endmodule

// File: rtl/panel_cfg_ctrl.sv
module panel_cfg_ctrl
  import panel_cfg_pkg::*;
#(
  parameter logic [15:0] MODE_MASK = 16'h6A00,
  parameter logic [15:0] DRV_BASE  = 16'h2AEF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cmd,
  input  logic       cmdValid,
  input  logic [15:0] mode,
  input  logic       frameDone,
  output frame_req_t req,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT} ctl_state_e;

  ctl_state_e  state;
  cfg_cmd_e    cmdReg;
  logic [15:0] modeReg;
  logic [1:0]  step;
  logic [1:0]  lastStep;
  logic [15:0] drvVal;
  logic [7:0]  regSel;
  logic [15:0] valSel;
  logic        isOff;

  assign isOff    = (cmdReg == CMD_SHUTDOWN) || (cmdReg == CMD_SUSPEND);
  assign lastStep = isOff ? 2'd1 : 2'd3;
  assign drvVal   = (DRV_BASE & ~MODE_MASK) | (modeReg & MODE_MASK);

  always_comb begin
    regSel = REG_SHUT;
    valSel = VAL_OFF;
    if (!isOff) begin
      // power-up: shut-ctl first; resume: output-ctl first
      if ((cmdReg == CMD_RESUME) ^ step[1]) begin
        regSel = REG_DRV;
        valSel = drvVal;
      end else begin
        regSel = REG_SHUT;
        valSel = VAL_ON;
      end
    end
  end

  assign req.launch = (state == C_ISSUE);
  assign req.frame  = step[0] ? {DAT_PREFIX, valSel} : {IDX_PREFIX, 8'h00, regSel};
  assign busy       = (state != C_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= C_IDLE;
      cmdReg  <= CMD_POWER_UP;
      modeReg <= '0;
      step    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        C_IDLE: begin
          if (cmdValid) begin
            cmdReg  <= cfg_cmd_e'(cmd);
            modeReg <= mode;
            step    <= '0;
            state   <= C_ISSUE;
          end
        end
        C_ISSUE: state <= C_WAIT;
        C_WAIT: begin
          if (frameDone) begin
            if (step == lastStep) begin
              done  <= 1'b1;
              state <= C_IDLE;
            end else begin
              step  <= step + 1'b1;
              state <= C_ISSUE;
            end
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  // R10: completion strobe lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: completion coincides with the end of busy
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));
  // R8: captured mode is held for the whole sequence
  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(modeReg));
  // R11: a running command cannot be replaced
  a_r11_cmd_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdReg));
endmodule

// File: rtl/panel_cfg_spi.sv
module panel_cfg_spi
  import panel_cfg_pkg::*;
#(
  parameter int          HALF_DIV  = 2,
  parameter logic [15:0] MODE_MASK = 16'h6A00,
  parameter logic [15:0] DRV_BASE  = 16'h2AEF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cmd,
  input  logic        cmdValid,
  input  logic [15:0] mode,
  output logic        busy,
  output logic        done,
  output logic        sclk,
  output logic        mosi,
  output logic        csN
);
  frame_req_t req;
  logic       frameDone;

  panel_cfg_ctrl #(
    .MODE_MASK(MODE_MASK),
    .DRV_BASE (DRV_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .cmdValid (cmdValid),
    .mode     (mode),
    .frameDone(frameDone),
    .req      (req),
    .busy     (busy),
    .done     (done)
  );

  panel_cfg_shifter #(
    .HALF_DIV(HALF_DIV)
  ) u_shift (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .frameDone(frameDone),
    .sclk     (sclk),
    .mosi     (mosi),
    .csN      (csN)
  );
endmodule

// File: tb/panel_cfg_spi_tb.sv
module panel_cfg_spi_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cmd = '0;
  logic        cmdValid = 1'b0;
  logic [15:0] mode = '0;
  logic        busy, done, sclk, mosi, csN;

  int tests = 0;
  int fails = 0;

  logic [23:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  panel_cfg_spi #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdValid(cmdValid), .mode(mode),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .csN(csN)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] idxF(input logic [7:0] r);
    return {8'h74, 8'h00, r};
  endfunction
  function automatic logic [23:0] datF(input logic [15:0] v);
    return {8'h76, v};
  endfunction

  task automatic pushWrite(input logic [7:0] r, input logic [15:0] v, input string tag);
    expQ.push_back(idxF(r)); tagQ.push_back({tag, "/R3 index"});
    expQ.push_back(datF(v)); tagQ.push_back({tag, "/R3 data"});
  endtask

  // monitor: rebuild frames from the pins
  logic [23:0] shIn = '0;
  int          bitN = 0;
  int          gapCyc = 100;
  int          riseGap = 0;
  logic        prevSclk = 1'b0;
  logic        prevCs = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (csN) gapCyc++;
      riseGap++;
      if (!csN && prevCs) begin
        check(gapCyc >= 2 * HALF, "R9 cs gap", gapCyc, 2 * HALF);
        bitN = 0;
        riseGap = 0;
      end
      if (!csN && sclk && !prevSclk) begin
        if (bitN > 0) check(riseGap == 2 * HALF, "R2 sclk period", riseGap, 2 * HALF);
        riseGap = 0;
        shIn = {shIn[22:0], mosi};
        bitN++;
      end
      if (csN && !prevCs) begin
        check(bitN == 24, "R2 bit count", bitN, 24);
        if (expQ.size() == 0) begin
          check(1'b0, "R11 unexpected frame", shIn, 0);
        end else begin
          logic [23:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(shIn == e, t, shIn, e);
        end
        gapCyc = 0;
      end
      prevSclk = sclk;
      prevCs = csN;
    end
  end

  task automatic issue(input logic [1:0] c, input logic [15:0] m);
    @(negedge clk);
    cmd = c; mode = m; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
  endtask

  task automatic finishCmd(input string tag);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done && !busy, {tag, "/R10 done ends busy"}, {done, busy}, 2'b10);
    check(expQ.size() == 0, {tag, "/R10 all frames before done"}, expQ.size(), 0);
    @(negedge clk);
    check(!done, {tag, "/R10 done single"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(csN == 1'b1, "R1 csN", csN, 1);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 power-up, R7 all-zero mode
    pushWrite(8'h11, 16'h0000, "R4 pwr shut-on");
    pushWrite(8'h01, 16'h00EF, "R4 R7 pwr drv m0");
    issue(2'd0, 16'h0000);
    finishCmd("R4");

    // R7 all-one mode
    pushWrite(8'h11, 16'h0000, "R4 pwr shut-on");
    pushWrite(8'h01, 16'h6AEF, "R7 pwr drv mFFFF");
    issue(2'd0, 16'hFFFF);
    finishCmd("R7");

    // R5 resume ordering, partial mask
    pushWrite(8'h01, 16'h42EF, "R5 res drv");
    pushWrite(8'h11, 16'h0000, "R5 res shut-on");
    issue(2'd2, 16'h4200);
    finishCmd("R5");

    // R6 shutdown and suspend
    pushWrite(8'h11, 16'h0001, "R6 shutdown");
    issue(2'd1, 16'h1234);
    finishCmd("R6 shutdown");
    pushWrite(8'h11, 16'h0001, "R6 suspend");
    issue(2'd3, 16'hFFFF);
    finishCmd("R6 suspend");

    // R8 mode change after acceptance
    pushWrite(8'h11, 16'h0000, "R8 pwr shut-on");
    pushWrite(8'h01, 16'h28EF, "R8 captured mode");
    issue(2'd0, 16'h2800);
    mode = 16'hFFFF;
    finishCmd("R8");

    // R11 command while busy, R7 bits outside mask ignored
    pushWrite(8'h01, 16'h02EF, "R11 R7 res drv");
    pushWrite(8'h11, 16'h0000, "R11 res shut-on");
    issue(2'd2, 16'h0300);
    repeat (30) @(negedge clk);
    cmd = 2'd1; mode = 16'h6A00; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    finishCmd("R11");
    repeat (200) @(negedge clk);
    check(csN && !busy, "R11 no later sequence", {csN, busy}, 2'b10);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule